// File: doc/BRIEF.md
# Two-Wire Slave Register Interface

This block is a slave on a two-wire serial bus (SCL plus an open-drain SDA) that lets a host reach two register banks. One bank is write-only: it holds the control bits that configure the rest of the chip and is presented on a parallel output. The other bank is read-only: it returns a status byte followed by values that the surrounding logic supplies. The block oversamples both bus lines with its own system clock, so SCL is treated as data and never used as a clock.

A write sends the address byte with the direction bit low, then a subaddress byte, then any number of data bytes. Each data byte goes to the control register at the current subaddress, and the subaddress then advances by one. A read cannot choose where to start. It always begins at subaddress 0, which is the status byte, and advances by one for each byte. The status byte carries a power-down flag and a fixed identification code. The flag is set by a pulse on the power-interruption input and is cleared once the status byte has been sent to the host. A strap pin selects one of two slave addresses.

Top module: `twowire_reg_slave`

## Requirements
- R1: The slave acknowledges an address byte (7-bit address plus direction bit) of 40H/41H when `addrSel` is 0 and E0H/E1H when `addrSel` is 1. Any other address byte receives no acknowledge, and the slave stays silent until the next START.
- R2: The slave drives SDA low as an acknowledge for the whole ninth clock of each matching address byte and of each byte it receives. It starts driving at the falling SCL edge that ends bit 8 and releases at the falling edge that ends the ninth clock.
- R3: In a write, the byte after the address is the subaddress. Each following data byte is stored in control register `ctrlRegs[8*s+7:8*s]`, where s is the current subaddress, and s then increments by one.
- R4: A data byte written at a subaddress of NUM_IN or above is still acknowledged, but it changes no control register.
- R5: Every read starts at subaddress 0, whatever subaddress an earlier write left behind, and sends bytes MSB first with the subaddress incrementing. Subaddress k from 1 to NUM_OUT-1 returns `rdRegs[8*(k-1)+7:8*(k-1)]`. Subaddresses of NUM_OUT and above return 00H.
- R6: The status byte (subaddress 0) holds the power-down flag in bit 7 and ID_CODE in bits 2:0. Bits 6:3 read as 0.
- R7: The power-down flag is 1 after reset and is set by any one-cycle pulse on `pwrFail`. It is cleared only after a status byte has been shifted out, so the read that clears the flag still returns it as 1. If a set pulse and a clear fall in the same cycle, the set wins.
- R8: After reset, `ctrlRegs` equals CTRL_RESET. With NUM_IN=4 this default is 0x0020_0080: register 0 has its range-select bit 7 set, register 2 holds 20H, and every other bit is 0. SDA is released after reset.
- R9: If the master does not acknowledge a read byte, the transfer ends. The slave keeps SDA released on every later clock until the next START.
- R10: The slave changes its SDA drive only while SCL is low, never during a high SCL phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to oversample SCL and SDA |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| sdaOe | output | 1 | 1 pulls SDA low; 0 releases it |
| addrSel | input | 1 | Strap that selects the slave address |
| pwrFail | input | 1 | Pulse that signals a supply interruption |
| rdRegs | input | 8*(NUM_OUT-1) | Values returned at subaddresses 1 and up |
| ctrlRegs | output | 8*NUM_IN | Contents of the write-only control bank |

## Verification
The bench builds the block with NUM_IN=4, NUM_OUT=3 and ID_CODE=110b, and keeps the default CTRL_RESET. With a four-register control bank, a burst of two bytes starting at subaddress 3 already runs past the end of the bank. With a three-slot read bank, a four-byte read reaches the 00H slots past the end. The non-default identification code shows that bits 2:0 of the status byte come from the parameter.

// File: rtl/tws_pkg.sv
package tws_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK_WR,
    ST_AACK_RD,
    ST_SUB,
    ST_SACK,
    ST_WDAT,
    ST_DACK,
    ST_RDAT,
    ST_MACK,
    ST_MACK_OK
  } twsState_e;

  // Strobes from the control FSM to the datapath; each lasts one cycle.
  typedef struct packed {
    logic shiftIn;    // take one received bit
    logic loadSub;    // received byte becomes the subaddress
    logic writeReg;   // received byte goes to the control bank
    logic startRd;    // pointer back to zero for a read
    logic loadTx;     // fetch the byte at the pointer for sending
    logic shiftTx;    // present the next transmit bit
    logic clrStatus;  // a transmitted byte has finished
  } twsStrobe_t;

endpackage

// File: rtl/tws_ctrl.sv
module tws_ctrl
  import tws_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       addrHit,
  input  logic       rwBit,
  output twsStrobe_t stb,
  output logic       sdaBit,
  output logic       ackDrv,
  output logic       datDrv
);

  localparam int unsigned PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] sclPipe;
  logic [PIPE_W-1:0] sdaPipe;
  logic sclS, sclPrev, sdaS, sdaPrev;
  logic sclRise, sclFall, startEv, stopEv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[PIPE_W-2:0], sclIn};
      sdaPipe <= {sdaPipe[PIPE_W-2:0], sdaIn};
    end
  end

  assign sclS    = sclPipe[SYNC_STAGES-1];
  assign sclPrev = sclPipe[SYNC_STAGES];
  assign sdaS    = sdaPipe[SYNC_STAGES-1];
  assign sdaPrev = sdaPipe[SYNC_STAGES];
  assign sdaBit  = sdaS;

  assign sclRise = sclS & ~sclPrev;
  assign sclFall = ~sclS & sclPrev;
  assign startEv = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopEv  = sclS & sclPrev & ~sdaPrev & sdaS;

  twsState_e  st, stNext;
  logic [3:0] bitCnt, cntNext;
  logic       ackNext, datNext;

  always_comb begin
    stNext  = st;
    cntNext = bitCnt;
    ackNext = ackDrv;
    datNext = datDrv;
    stb     = '0;
    if (stopEv) begin
      stNext  = ST_IDLE;
      ackNext = 1'b0;
      datNext = 1'b0;
    end else if (startEv) begin
      stNext  = ST_ADDR;
      cntNext = '0;
      ackNext = 1'b0;
      datNext = 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: ;
        ST_ADDR, ST_SUB, ST_WDAT: begin
          if (sclRise && bitCnt < 4'd8) begin
            stb.shiftIn = 1'b1;
            cntNext     = bitCnt + 4'd1;
          end
          if (sclFall && bitCnt == 4'd8) begin
            cntNext = '0;
            if (st == ST_ADDR) begin
              if (addrHit) begin
                ackNext = 1'b1;
                if (rwBit) begin
                  stNext      = ST_AACK_RD;
                  stb.startRd = 1'b1;
                end else begin
                  stNext = ST_AACK_WR;
                end
              end else begin
                stNext = ST_IDLE;
              end
            end else if (st == ST_SUB) begin
              ackNext     = 1'b1;
              stb.loadSub = 1'b1;
              stNext      = ST_SACK;
            end else begin
              ackNext      = 1'b1;
              stb.writeReg = 1'b1;
              stNext       = ST_DACK;
            end
          end
        end
        ST_AACK_WR, ST_SACK, ST_DACK: begin
          if (sclFall) begin
            ackNext = 1'b0;
            stNext  = (st == ST_AACK_WR) ? ST_SUB : ST_WDAT;
          end
        end
        ST_AACK_RD, ST_MACK_OK: begin
          if (sclFall) begin
            ackNext    = 1'b0;
            datNext    = 1'b1;
            stb.loadTx = 1'b1;
            stNext     = ST_RDAT;
          end
        end
        ST_RDAT: begin
          if (sclRise) cntNext = bitCnt + 4'd1;
          if (sclFall) begin
            if (bitCnt == 4'd8) begin
              datNext       = 1'b0;
              stb.clrStatus = 1'b1;
              cntNext       = '0;
              stNext        = ST_MACK;
            end else begin
              stb.shiftTx = 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (sclRise) stNext = sdaS ? ST_IDLE : ST_MACK_OK;
        end
        default: stNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st     <= ST_IDLE;
      bitCnt <= '0;
      ackDrv <= 1'b0;
      datDrv <= 1'b0;
    end else begin
      st     <= stNext;
      bitCnt <= cntNext;
      ackDrv <= ackNext;
      datDrv <= datNext;
    end
  end

  // R10
  ack_on_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackDrv) |-> $past(sclFall));

  // R10
  data_on_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(datDrv) |-> $past(sclFall));

  // R9
  idle_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_IDLE) |-> (!ackDrv && !datDrv));

  // R3
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadSub, stb.writeReg, stb.startRd, stb.loadTx, stb.shiftIn}));

endmodule

// File: rtl/tws_datapath.sv
module tws_datapath
  import tws_pkg::*;
#(
  parameter int unsigned NUM_IN  = 4,
  parameter int unsigned NUM_OUT = 4,
  parameter logic [2:0]  ID_CODE = 3'b101,
  parameter logic [NUM_IN*8-1:0] CTRL_RESET = 'h0020_0080,
  parameter logic [6:0]  ADDR_LO = 7'h20,
  parameter logic [6:0]  ADDR_HI = 7'h70
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  twsStrobe_t             stb,
  input  logic                   sdaBit,
  input  logic                   addrSel,
  input  logic                   pwrFail,
  input  logic [NUM_OUT*8-9:0]   rdRegs,
  output logic [NUM_IN*8-1:0]    ctrlRegs,
  output logic                   addrHit,
  output logic                   rwBit,
  output logic                   txBit
);

  localparam int unsigned OUT_IW    = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1;
  localparam int unsigned OUT_SLOTS = 2 ** OUT_IW;
  localparam logic [7:0]  OUT_LIM   = 8'(NUM_OUT);
  localparam logic [7:0]  IN_LIM    = 8'(NUM_IN);

  logic [7:0] shReg, txReg, ptr, curIdx, rdByte, statusByte;
  logic       pdd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shReg <= '0;
    else if (stb.shiftIn) shReg <= {shReg[6:0], sdaBit};
  end

  assign addrHit = (shReg[7:1] == (addrSel ? ADDR_HI : ADDR_LO));
  assign rwBit   = shReg[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr    <= '0;
      curIdx <= '0;
      txReg  <= '1;
    end else begin
      if (stb.startRd) ptr <= '0;
      else if (stb.loadSub) ptr <= shReg;
      else if (stb.writeReg) ptr <= ptr + 8'd1;
      else if (stb.loadTx) begin
        ptr    <= ptr + 8'd1;
        curIdx <= ptr;
        txReg  <= rdByte;
      end else if (stb.shiftTx) begin
        txReg <= {txReg[6:0], 1'b1};
      end
    end
  end

  assign txBit = txReg[7];

  for (genvar g = 0; g < NUM_IN; g++) begin : gCtrl
    logic [7:0] regQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regQ <= CTRL_RESET[g*8 +: 8];
      else if (stb.writeReg && ptr == 8'(g)) regQ <= shReg;
    end
    assign ctrlRegs[g*8 +: 8] = regQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pdd <= 1'b1;
    else if (pwrFail) pdd <= 1'b1;
    else if (stb.clrStatus && curIdx == 8'd0) pdd <= 1'b0;
  end

  assign statusByte = {pdd, 4'b0000, ID_CODE};

  logic [7:0] rdArr [OUT_SLOTS];
  assign rdArr[0] = statusByte;
  for (genvar k = 1; k < OUT_SLOTS; k++) begin : gRd
    if (k < NUM_OUT) begin : gUsed
      assign rdArr[k] = rdRegs[(k-1)*8 +: 8];
    end else begin : gSpare
      assign rdArr[k] = 8'h00;
    end
  end

  assign rdByte = (ptr < OUT_LIM) ? rdArr[ptr[OUT_IW-1:0]] : 8'h00;

  // R7
  pdd_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    pwrFail |=> pdd);

  // R7
  pdd_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pdd) |-> $past(stb.clrStatus));

  // R3
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.writeReg |=> $stable(ctrlRegs));

  // R4
  ctrl_overrun_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.writeReg && ptr >= IN_LIM) |=> $stable(ctrlRegs));

endmodule

// File: rtl/twowire_reg_slave.sv
module twowire_reg_slave
  import tws_pkg::*;
#(
  parameter int unsigned NUM_IN  = 4,
  parameter int unsigned NUM_OUT = 4,
  parameter logic [2:0]  ID_CODE = 3'b101,
  parameter logic [NUM_IN*8-1:0] CTRL_RESET = 'h0020_0080,
  parameter logic [6:0]  ADDR_LO = 7'h20,
  parameter logic [6:0]  ADDR_HI = 7'h70,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  output logic                 sdaOe,
  input  logic                 addrSel,
  input  logic                 pwrFail,
  input  logic [NUM_OUT*8-9:0] rdRegs,
  output logic [NUM_IN*8-1:0]  ctrlRegs
);

  twsStrobe_t stb;
  logic sdaBit, addrHit, rwBit, txBit, ackDrv, datDrv;

  tws_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrHit(addrHit), .rwBit(rwBit), .stb(stb), .sdaBit(sdaBit),
    .ackDrv(ackDrv), .datDrv(datDrv)
  );

  tws_datapath #(
    .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .ID_CODE(ID_CODE),
    .CTRL_RESET(CTRL_RESET), .ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaBit(sdaBit), .addrSel(addrSel),
    .pwrFail(pwrFail), .rdRegs(rdRegs), .ctrlRegs(ctrlRegs),
    .addrHit(addrHit), .rwBit(rwBit), .txBit(txBit)
  );

  assign sdaOe = ackDrv | (datDrv & ~txBit);

endmodule

// File: tb/twowire_reg_slave_bench.sv
module twowire_reg_slave_bench;

  localparam int Q = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic addrSel = 1'b0;
  logic pwrFail = 1'b0;
  logic [15:0] rdRegs = 16'hC35A;
  logic sdaOe, sdaBus;
  logic [31:0] ctrlRegs;
  int tests = 0;
  int fails = 0;
  int edgeViol = 0;
  logic prevScl = 1'b1;
  logic prevOe = 1'b0;

  always #4 clk = ~clk;

  assign sdaBus = sdaM & ~sdaOe;

  twowire_reg_slave #(.NUM_IN(4), .NUM_OUT(3), .ID_CODE(3'b110)) u_twowire_reg_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .addrSel(addrSel), .pwrFail(pwrFail), .rdRegs(rdRegs), .ctrlRegs(ctrlRegs)
  );

  // R10 monitor: SDA drive must not move while SCL stays high
  always @(posedge clk) begin
    if (rstN && sclM && prevScl && (sdaOe != prevOe)) edgeViol++;
    prevScl = sclM;
    prevOe  = sdaOe;
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ();
  endtask

  task automatic putBit(input logic b);
    sdaM = b; waitQ();
    sclM = 1'b1; waitQ(); waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic getBit(output logic b, output logic oeHigh);
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    b = sdaBus; oeHigh = sdaOe; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic putByte(input logic [7:0] d, output logic acked);
    logic b, oe;
    for (int i = 7; i >= 0; i--) putBit(d[i]);
    getBit(b, oe);
    acked = ~b;
  endtask

  task automatic getByte(output logic [7:0] d, input logic ackIt);
    logic b, oe;
    for (int i = 7; i >= 0; i--) begin
      getBit(b, oe);
      d[i] = b;
    end
    putBit(~ackIt);
  endtask

  task automatic testReset();
    chk("R8 ctrl reset value", ctrlRegs, 32'h0020_0080);
    chk("R8 sda released after reset", {31'd0, sdaOe}, 32'd0);
  endtask

  task automatic testWrongAddr();
    logic a;
    busStart(); putByte(8'h42, a); busStop();
    chk("R1 foreign address not acked", {31'd0, a}, 32'd0);
    busStart(); putByte(8'hE0, a); busStop();
    chk("R1 strap-high address not acked while strap low", {31'd0, a}, 32'd0);
    chk("R1 no write from foreign address", ctrlRegs, 32'h0020_0080);
  endtask

  task automatic testWriteBurst();
    logic a0, a1, a2, a3;
    busStart(); putByte(8'h40, a0); putByte(8'h01, a1);
    putByte(8'hA5, a2); putByte(8'h3C, a3); busStop();
    chk("R2 acks on address, subaddress, data", {28'd0, a0, a1, a2, a3}, 32'hF);
    chk("R3 burst with auto-increment", ctrlRegs, 32'h003C_A580);
  endtask

  task automatic testWriteOverrun();
    logic a0, a1, a2, a3;
    busStart(); putByte(8'h40, a0); putByte(8'h03, a1);
    putByte(8'h11, a2); putByte(8'h22, a3); busStop();
    chk("R4 byte past bank still acked", {31'd0, a3}, 32'd1);
    chk("R4 only in-range register changed", ctrlRegs, 32'h113C_A580);
  endtask

  task automatic testReadSeq();
    logic a;
    logic [7:0] d0, d1, d2, d3;
    busStart(); putByte(8'h40, a); putByte(8'h02, a); busStop();
    busStart(); putByte(8'h41, a);
    chk("R1 read address acked", {31'd0, a}, 32'd1);
    getByte(d0, 1'b1); getByte(d1, 1'b1); getByte(d2, 1'b1); getByte(d3, 1'b0);
    busStop();
    chk("R7 R6 first status read shows flag set", {24'd0, d0}, 32'h86);
    chk("R5 read bank slot 1", {24'd0, d1}, 32'h5A);
    chk("R5 read bank slot 2", {24'd0, d2}, 32'hC3);
    chk("R5 past read bank gives zero", {24'd0, d3}, 32'h00);
    busStart(); putByte(8'h41, a); getByte(d0, 1'b0); busStop();
    chk("R7 flag cleared by previous read", {24'd0, d0}, 32'h06);
  endtask

  task automatic testPowerFail();
    logic a;
    logic [7:0] d;
    @(negedge clk); pwrFail = 1'b1; @(negedge clk); pwrFail = 1'b0;
    busStart(); putByte(8'h41, a); getByte(d, 1'b0); busStop();
    chk("R7 pulse sets flag", {24'd0, d}, 32'h86);
    busStart(); putByte(8'h41, a); getByte(d, 1'b0); busStop();
    chk("R7 flag cleared after status read", {24'd0, d}, 32'h06);
  endtask

  task automatic testStrapHigh();
    logic a0, a1, a2;
    addrSel = 1'b1;
    busStart(); putByte(8'h40, a0); busStop();
    chk("R1 low address ignored with strap high", {31'd0, a0}, 32'd0);
    busStart(); putByte(8'hE0, a0); putByte(8'h00, a1); putByte(8'h7E, a2); busStop();
    chk("R1 strap-high address acked", {29'd0, a0, a1, a2}, 32'h7);
    chk("R3 write via strap-high address", ctrlRegs, 32'h113C_A57E);
    addrSel = 1'b0;
  endtask

  task automatic testNackRelease();
    logic a, b, oe;
    logic [7:0] d;
    int seen;
    seen = 0;
    busStart(); putByte(8'h41, a); getByte(d, 1'b0);
    for (int i = 0; i < 9; i++) begin
      getBit(b, oe);
      if (oe || !b) seen++;
    end
    busStop();
    chk("R9 released after master NACK", seen, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testWrongAddr();
    testWriteBurst();
    testWriteOverrun();
    testReadSeq();
    testPowerFail();
    testStrapHigh();
    testNackRelease();
    chk("R10 drive changes only while SCL low", edgeViol, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule